// File: doc/BRIEF.md
# Programmable Down-Counting Timer

A single timer channel behind a small word-addressed register port. Software sets a start count and a reload count. It picks a tick rate of every clock, every 16 clocks or every 256 clocks. It chooses a counter width of 16 or 32 bits and one of three behaviours for when the count runs out: wrap around, reload, or stop. The counter steps down by one on each tick. When it reaches zero it latches a raw interrupt flag. An interrupt line follows that flag, gated by an enable bit.

The port takes a 3-bit word index (byte offset divided by four), a write strobe and a 32-bit write value. Reads are combinational from the word index. Two registers set the reload value. The immediate one also loads the counter and restarts the tick divider. The background one changes only the value used at the next periodic reload. The current count is also provided directly as an output.

Top module: `tick_timer`

## Requirements
- R1: After reset, control reads 0, load and background registers read 0xFFFFFFFF, current count reads 0x0000FFFF (16-bit mode is the reset width), raw and masked status read 0 and irq_o is low.
- R2: Word index 2 reads control as {24'b0, enable[7], periodic[6], irq_enable[5], 1'b0, prescale[3:2], wide[1], oneshot[0]}. Word indices 3 and 7 read as zero.
- R3: Writing word index 0 loads the counter with the written value on the next edge. It also sets the reload value and restarts the tick divider, so with divide-by-16 the first decrement comes 16 enabled cycles later.
- R4: Writing word index 6 sets the reload value only; the current count is unchanged. Word indices 0 and 6 both read back the reload value.
- R5: Prescale field 2'b00 and 2'b11 tick every enabled cycle, 2'b01 every 16th and 2'b10 every 256th enabled cycle. The divider advances only while the enable bit is set.
- R6: The count decrements by one per tick while enabled and holds while disabled. The count is readable at word index 1 and on count_o.
- R7: A tick that takes the count from 1 to 0 sets the raw flag (word index 4, bit 0). A tick in the same cycle as a load write does not count.
- R8: In periodic mode (periodic bit set, one-shot bit clear) a tick at zero reloads the count from the reload value.
- R9: In free-running mode (both mode bits clear) a tick at zero wraps the count to 0xFFFF or 0xFFFFFFFF according to the width bit.
- R10: In one-shot mode (one-shot bit set, which takes priority over the periodic bit) the count holds at zero and the enable bit clears in the same edge that sets the flag.
- R11: With the width bit clear only the low 16 bits count and reload, and the count reads with its upper 16 bits zero.
- R12: Any write to word index 3 clears the raw flag, unless a zero-crossing occurs in the same cycle, in which case the flag stays set.
- R13: Word index 5 reads raw flag AND interrupt enable, and irq_o is a register output equal to that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Masked interrupt |
| count_o | output | 32 | Current count as read |

## Verification
A zero-crossing in the same cycle as an interrupt-clear write is targeted. A design where the clear wins would lose an interrupt. A load write during a divide-by-16 run checks the divider restart. A design that keeps the old divider phase decrements too early. A background write during counting checks that a design which also loads the counter is caught by an altered current value. One-shot completion, free-running wrap in 16-bit mode and the reserved-code prescale are each checked with exact counts. A random mix of writes is then compared every cycle against a bench model.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    SEL_LOAD = 3'd0,
    SEL_CUR  = 3'd1,
    SEL_CTRL = 3'd2,
    SEL_ICLR = 3'd3,
    SEL_RAW  = 3'd4,
    SEL_MSK  = 3'd5,
    SEL_BG   = 3'd6,
    SEL_RSV  = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    PS_DIV1   = 2'b00,
    PS_DIV16  = 2'b01,
    PS_DIV256 = 2'b10,
    PS_ALT1   = 2'b11
  } presc_e;

  typedef struct packed {
    logic   en;
    logic   per;
    logic   ie;
    presc_e presc;
    logic   wide;
    logic   one;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_word(input logic [WORD_W-1:0] w);
    ctrl_t c;
    c.en    = w[7];
    c.per   = w[6];
    c.ie    = w[5];
    c.presc = presc_e'(w[3:2]);
    c.wide  = w[1];
    c.one   = w[0];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] ctrl_to_word(input ctrl_t c);
    return {{(WORD_W-8){1'b0}}, c.en, c.per, c.ie, 1'b0, c.presc, c.wide, c.one};
  endfunction
endpackage

// File: rtl/tick_timer_presc.sv
module tick_timer_presc
  import tick_timer_pkg::*;
#(
  parameter int unsigned MID_LOG = 4,
  parameter int unsigned HI_LOG  = 8
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  logic   restart_i,
  input  presc_e sel_i,
  output logic   tick_o
);
  localparam int unsigned PW = HI_LOG;

  logic [PW-1:0] p_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        p_q <= '0;
    else if (restart_i) p_q <= '0;
    else if (en_i)      p_q <= p_q + 1'b1;
  end

  always_comb begin
    unique case (sel_i)
      PS_DIV16:  tick_o = en_i & (&p_q[MID_LOG-1:0]);
      PS_DIV256: tick_o = en_i & (&p_q);
      default:   tick_o = en_i;
    endcase
  end

  // R5
  div16_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_i == PS_DIV16) |=> (!tick_o || sel_i != PS_DIV16));
endmodule

// File: rtl/tick_timer_cnt.sv
module tick_timer_cnt
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W    = WORD_W,
  parameter int unsigned NARROW_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             bg_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             tick_i,
  input  logic             wide_i,
  input  logic             periodic_i,
  input  logic             oneshot_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] NARROW_MASK = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, rel_q, mask, eff;
  logic             at_zero;

  assign mask    = wide_i ? '1 : NARROW_MASK;
  assign eff     = cnt_q & mask;
  assign at_zero = (eff == '0);
  assign hit_o   = tick_i & ~load_i & (eff == ONE);
  assign count_o = eff;
  assign reload_o = rel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      rel_q <= '1;
    end else if (load_i) begin
      cnt_q <= val_i;
      rel_q <= val_i;
    end else begin
      if (bg_i) rel_q <= val_i;
      if (tick_i) begin
        if (at_zero && periodic_i)     cnt_q <= rel_q;
        else if (at_zero && oneshot_i) cnt_q <= cnt_q;
        else                           cnt_q <= (eff - ONE) & mask;
      end
    end
  end

  // R3
  load_now_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_o == ($past(val_i) & mask));

  // R7
  hit_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> count_o == '0);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned MID_LOG  = 4,
  parameter int unsigned HI_LOG   = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
  ,output logic [31:0] count_o
);
  reg_sel_e sel;
  ctrl_t    ctrl_q, ctrl_d;
  logic     raw_q, raw_d, irq_q;
  logic     ld_wr, bg_wr, ctrl_wr, clr_wr;
  logic     tick, hit;
  logic [WORD_W-1:0] cur, rel;

  assign sel     = reg_sel_e'(addr_i);
  assign ld_wr   = wr_i & (sel == SEL_LOAD);
  assign bg_wr   = wr_i & (sel == SEL_BG);
  assign ctrl_wr = wr_i & (sel == SEL_CTRL);
  assign clr_wr  = wr_i & (sel == SEL_ICLR);

  tick_timer_presc #(.MID_LOG(MID_LOG), .HI_LOG(HI_LOG)) u_presc (
    .clk_i, .rst_ni,
    .en_i      (ctrl_q.en),
    .restart_i (ld_wr),
    .sel_i     (ctrl_q.presc),
    .tick_o    (tick)
  );

  tick_timer_cnt #(.CNT_W(WORD_W), .NARROW_W(NARROW_W)) u_cnt (
    .clk_i, .rst_ni,
    .load_i     (ld_wr),
    .bg_i       (bg_wr),
    .val_i      (wdata_i),
    .tick_i     (tick),
    .wide_i     (ctrl_q.wide),
    .periodic_i (ctrl_q.per & ~ctrl_q.one),
    .oneshot_i  (ctrl_q.one),
    .count_o    (cur),
    .reload_o   (rel),
    .hit_o      (hit)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr)                ctrl_d = ctrl_from_word(wdata_i);
    else if (hit && ctrl_q.one) ctrl_d.en = 1'b0;
    raw_d = hit | (raw_q & ~clr_wr);  // set beats clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      raw_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      raw_q  <= raw_d;
      irq_q  <= raw_d & ctrl_d.ie;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_LOAD, SEL_BG: rdata_o = rel;
      SEL_CUR:          rdata_o = cur;
      SEL_CTRL:         rdata_o = ctrl_to_word(ctrl_q);
      SEL_RAW:          rdata_o = {31'd0, raw_q};
      SEL_MSK:          rdata_o = {31'd0, raw_q & ctrl_q.ie};
      default:          rdata_o = '0;
    endcase
  end

  assign irq_o   = irq_q;
  assign count_o = cur;

  // R10
  oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && ctrl_q.one && !ctrl_wr) |=> !ctrl_q.en);

  // R12
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> raw_q);

  // R13
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (raw_q & ctrl_q.ie));
endmodule

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;
  localparam time CLK_P = 8ns;
  localparam logic [2:0] A_LOAD = 3'd0, A_CUR = 3'd1, A_CTRL = 3'd2, A_ICLR = 3'd3,
                         A_RAW = 3'd4, A_MSK = 3'd5, A_BG = 3'd6, A_RSV = 3'd7;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o, count_o;
  logic        irq_o;

  int n_vec = 0;
  int n_err = 0;

  logic [31:0] m_cnt = 32'hFFFF_FFFF, m_rel = 32'hFFFF_FFFF, m_ctrl = '0;
  logic        m_raw = 1'b0;
  logic [7:0]  m_p = '0;

  always #(CLK_P/2) clk = ~clk;

  tick_timer u_dut (
    .clk_i(clk), .rst_ni, .wr_i, .addr_i, .wdata_i, .rdata_o, .irq_o, .count_o
  );

  function automatic logic [31:0] m_mask();
    return m_ctrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      A_LOAD, A_BG: return m_rel;
      A_CUR:        return m_cnt & m_mask();
      A_CTRL:       return m_ctrl;
      A_RAW:        return {31'd0, m_raw};
      A_MSK:        return {31'd0, m_raw & m_ctrl[5]};
      default:      return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      A_LOAD:  return "R3";
      A_CUR:   return "R6";
      A_CTRL:  return "R10";
      A_RAW:   return "R12";
      A_MSK:   return "R13";
      A_BG:    return "R4";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model(input bit wr, input logic [2:0] a, input logic [31:0] d);
    logic [31:0] mask, eff, ncnt;
    logic tick, ld, bg, cw, clr, hit, one, per, en;
    mask = m_mask();
    eff  = m_cnt & mask;
    en   = m_ctrl[7];
    case (m_ctrl[3:2])
      2'b01:   tick = en && (m_p[3:0] == 4'hF);
      2'b10:   tick = en && (m_p == 8'hFF);
      default: tick = en;
    endcase
    ld  = wr && a == A_LOAD;
    bg  = wr && a == A_BG;
    cw  = wr && a == A_CTRL;
    clr = wr && a == A_ICLR;
    hit = tick && !ld && eff == 32'd1;
    one = m_ctrl[0];
    per = m_ctrl[6] && !one;
    ncnt = m_cnt;
    if (ld) ncnt = d;
    else if (tick) begin
      if (eff == 0 && per)      ncnt = m_rel;
      else if (eff == 0 && one) ncnt = m_cnt;
      else                      ncnt = (eff - 32'd1) & mask;
    end
    m_cnt = ncnt;
    if (ld || bg) m_rel = d;
    if (ld) m_p = '0; else if (en) m_p = m_p + 8'd1;
    m_raw = hit | (m_raw & !clr);
    if (cw) m_ctrl = d & 32'h0000_00EF;
    else if (hit && one) m_ctrl[7] = 1'b0;
  endtask

  task automatic step(input bit wr, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_i = wr; addr_i = a; wdata_i = d;
    @(posedge clk);
    model(wr, a, d);
    #1;
    chk(count_o, m_cnt & m_mask(), "R6");
    chk({31'd0, irq_o}, {31'd0, m_raw & m_ctrl[5]}, "R13");
    chk(rdata_o, m_read(a), tag_of(a));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, A_CUR, 32'd0);
  endtask

  task automatic prep(input logic [31:0] ld, input logic [31:0] ctl);
    step(1'b1, A_CTRL, 32'd0);
    step(1'b1, A_ICLR, 32'd0);
    step(1'b1, A_LOAD, ld);
    step(1'b1, A_CTRL, ctl);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_err++;
    $display("FAIL R6 watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk(count_o, 32'h0000_FFFF, "R1");
    chk({31'd0, irq_o}, 32'd0, "R1");
    for (int a = 0; a < 8; a++) step(1'b0, 3'(a), 32'd0);
    chk(rdata_o, 32'd0, "R1");

    // R2 control readback drops bit 4 and upper bits
    step(1'b1, A_CTRL, 32'hFFFF_FF7F);
    chk(rdata_o, 32'h0000_006F, "R2");

    // R5 divide by 16
    step(1'b1, A_CTRL, 32'd0);
    step(1'b1, A_LOAD, 32'd100);
    step(1'b1, A_CTRL, 32'h84);
    idle(15);
    chk(count_o, 32'd100, "R5");
    idle(1);
    chk(count_o, 32'd99, "R5");
    // R3 load restarts the divider
    idle(5);
    step(1'b1, A_LOAD, 32'd20);
    idle(15);
    chk(count_o, 32'd20, "R3");
    idle(1);
    chk(count_o, 32'd19, "R3");

    // R5 code 11 behaves as divide by 1
    prep(32'd50, 32'h8C);
    idle(3);
    chk(count_o, 32'd47, "R5");

    // R7 / R9 free-running crossing and wrap
    prep(32'd2, 32'h80);
    step(1'b0, A_RAW, 32'd0);
    chk(rdata_o, 32'd0, "R7");
    step(1'b0, A_RAW, 32'd0);
    chk(rdata_o, 32'd1, "R7");
    chk(count_o, 32'd0, "R7");
    idle(1);
    chk(count_o, 32'h0000_FFFF, "R9");

    // R8 periodic reload
    prep(32'd3, 32'hC2);
    idle(3);
    chk(count_o, 32'd0, "R8");
    idle(1);
    chk(count_o, 32'd3, "R8");

    // R10 one-shot stops and clears enable
    prep(32'd2, 32'hC1);
    idle(1);
    step(1'b0, A_CTRL, 32'd0);
    chk(rdata_o, 32'h41, "R10");
    idle(3);
    chk(count_o, 32'd0, "R10");

    // R11 width select
    step(1'b1, A_CTRL, 32'd0);
    step(1'b1, A_LOAD, 32'h1234_5678);
    chk(count_o, 32'h0000_5678, "R11");
    step(1'b1, A_CTRL, 32'h02);
    chk(count_o, 32'h1234_5678, "R11");

    // R12 crossing in the same cycle as a clear: set wins
    prep(32'd2, 32'h80);
    idle(1);
    step(1'b1, A_ICLR, 32'd0);
    step(1'b0, A_RAW, 32'd0);
    chk(rdata_o, 32'd1, "R12");
    step(1'b1, A_ICLR, 32'd0);
    step(1'b0, A_RAW, 32'd0);
    chk(rdata_o, 32'd0, "R12");

    // R13 masked interrupt
    prep(32'd1, 32'hA0);
    idle(1);
    chk({31'd0, irq_o}, 32'd1, "R13");
    step(1'b1, A_CTRL, 32'h80);
    chk({31'd0, irq_o}, 32'd0, "R13");
    step(1'b0, A_RAW, 32'd0);
    chk(rdata_o, 32'd1, "R13");

    // R4 background load leaves count alone
    step(1'b1, A_CTRL, 32'd0);
    step(1'b1, A_LOAD, 32'd10);
    step(1'b1, A_BG, 32'd7);
    chk(count_o, 32'd10, "R4");
    step(1'b1, A_CTRL, 32'hC2);
    idle(10);
    chk(count_o, 32'd0, "R4");
    step(1'b0, A_LOAD, 32'd0);
    chk(count_o, 32'd7, "R4");
    chk(rdata_o, 32'd7, "R4");

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      logic [2:0]  a;
      logic [31:0] d;
      bit          w;
      a = 3'($urandom_range(0, 7));
      w = ($urandom_range(0, 99) < 25);
      d = $urandom;
      if (a == A_LOAD || a == A_BG)
        if ($urandom_range(0, 9) < 8) d = 32'($urandom_range(0, 40));
      if (a == A_CTRL && $urandom_range(0, 3) != 0) d[7] = 1'b1;
      if (a == A_CTRL && d[3:2] == 2'b10 && $urandom_range(0, 3) != 0) d[3:2] = 2'b00;
      step(w, a, d);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule